// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the two upstream USB data lines, taken on the 12 MHz core clock, and decides when the host is driving a bus reset. A bus reset shows up as a single-ended zero (SE0), where both lines sit low. The block measures how long each SE0 lasts. It recognises a reset once the SE0 has lasted a programmable number of clock cycles. The default is 168 cycles, which is 14 µs. That value lies safely between the shortest SE0 that must be ignored (12 µs) and the longest that may still go unrecognised (16 µs).

When a reset is recognised, the block does three things. It sets a sticky status flag. It pulses a one-cycle clear to the device address registers. It raises a startup-abort level that stops any power-on startup delay still running. The interrupt request is not raised at that point. It comes as a one-cycle pulse when the SE0 ends, and only if that same SE0 reached the threshold. Software clears the status flag by writing a zero to it.

The line inputs are asynchronous. They pass through a synchroniser (two stages by default) before the duration counter sees them. The counter stops at the threshold instead of wrapping around, so an SE0 of any length is recognised exactly once.

Top module: `usb_busrst_det`

## Requirements
- R1: During reset (rst_n low) and in the first cycle after it, reset_flag, reset_irq, addr_clear and startup_abort are all 0.
- R2: SE0 means dp_in = 0 and dm_in = 0. Every other line state ends or breaks an SE0: dp_in=1/dm_in=0, dp_in=0/dm_in=1, and dp_in=1/dm_in=1.
- R3: An SE0 held on the inputs for N consecutive clock edges is recognised only when N >= THRESH_CYC (default 168). With N = THRESH_CYC - 1, no output changes.
- R4: For an SE0 first present at edge e1, recognition shows in the cycle after edge e(THRESH_CYC+2). In that cycle addr_clear is 1 for exactly one cycle, and reset_flag and startup_abort become 1.
- R5: The duration counter saturates. An SE0 of any length above the threshold produces exactly one addr_clear pulse and one reset_irq pulse.
- R6: reset_irq is a one-cycle pulse, issued two edges after the SE0 leaves the inputs, and only when that SE0 episode was recognised.
- R7: startup_abort stays at 1 from recognition until the edge that issues reset_irq, and is 0 from then on.
- R8: reset_flag is sticky. Writing flag_wr=1 with flag_wdata=0 clears it at the next edge. Writing flag_wdata=1 has no effect.
- R9: If recognition and a clearing write happen at the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_in | input | 1 | D+ line level, asynchronous |
| dm_in | input | 1 | D- line level, asynchronous |
| flag_wr | input | 1 | Software write strobe for the status flag |
| flag_wdata | input | 1 | Written value; 0 clears the flag |
| reset_flag | output | 1 | Sticky "bus reset seen" status |
| reset_irq | output | 1 | One-cycle interrupt at the end of a recognised reset |
| addr_clear | output | 1 | One-cycle clear of the device address registers |
| startup_abort | output | 1 | Aborts the power-on startup delay while a recognised reset lasts |

## Verification
A wrong duration count would show at the ports within one threshold period. addr_clear would appear one edge too early or too late against an SE0 that was placed exactly, or it would fire for an SE0 one cycle too short. A counter that wraps instead of saturating would produce a second addr_clear pulse on a long SE0. A stale recognition state would show in one of two ways: a spurious reset_irq after a short SE0, or startup_abort staying high after the line has recovered. The bench compares every output against its model on every clock, so each of these faults is caught in the cycle it first appears.

// File: rtl/usb_busrst_pkg.sv
package usb_busrst_pkg;
  // 14 us at 12 MHz; must lie inside the 12..16 us tolerance window
  localparam int unsigned THRESH_CYC  = 168;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned LINE_W      = 2;

  typedef struct packed {
    logic dp;
    logic dm;
  } line_t;

  // idle full-speed J state used as the synchroniser reset value
  localparam line_t LINE_IDLE = '{dp: 1'b1, dm: 1'b0};
endpackage

// File: rtl/usb_busrst_sync.sv
module usb_busrst_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < int'(STAGES); g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/usb_busrst_timer.sv
module usb_busrst_timer #(
  parameter int unsigned THRESH = 168
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  output logic arm,     // this edge brings the count to the threshold
  output logic at_max
);
  localparam int unsigned CNT_W = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] PRE  = CNT_W'(THRESH - 1);

  logic [CNT_W-1:0] cnt_q;

  assign at_max = (cnt_q == MAXV);
  assign arm    = se0 && (cnt_q == PRE);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!se0)   cnt_q <= '0;
    else if (!at_max) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/usb_busrst_event.sv
module usb_busrst_event (
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  input  logic arm,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic reset_flag,
  output logic reset_irq,
  output logic addr_clear,
  output logic startup_abort
);
  logic active_q, flag_q, irq_q, clr_q;
  logic sw_clear;

  assign sw_clear = flag_wr && !flag_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      clr_q <= arm;
      irq_q <= active_q && !se0;
      if (arm)       active_q <= 1'b1;
      else if (!se0) active_q <= 1'b0;
      if (arm)           flag_q <= 1'b1;
      else if (sw_clear) flag_q <= 1'b0;
    end
  end

  assign reset_flag    = flag_q;
  assign reset_irq     = irq_q;
  assign addr_clear    = clr_q;
  assign startup_abort = active_q;
endmodule

// File: rtl/usb_busrst_det.sv
module usb_busrst_det
  import usb_busrst_pkg::*;
#(
  parameter int unsigned THRESH = THRESH_CYC,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_in,
  input  logic dm_in,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic reset_flag,
  output logic reset_irq,
  output logic addr_clear,
  output logic startup_abort
);
  line_t line_raw, line_s;
  logic  se0_s, arm, at_max;

  assign line_raw = '{dp: dp_in, dm: dm_in};

  usb_busrst_sync #(
    .WIDTH(LINE_W), .STAGES(STAGES), .RST_VAL(LINE_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(line_raw), .q_sync(line_s)
  );

  assign se0_s = !line_s.dp && !line_s.dm;

  usb_busrst_timer #(.THRESH(THRESH)) u_tmr (
    .clk(clk), .rst_n(rst_n), .se0(se0_s), .arm(arm), .at_max(at_max)
  );

  usb_busrst_event u_evt (
    .clk(clk), .rst_n(rst_n), .se0(se0_s), .arm(arm),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .reset_flag(reset_flag), .reset_irq(reset_irq),
    .addr_clear(addr_clear), .startup_abort(startup_abort)
  );
endmodule

// File: rtl/usb_busrst_chk.sv
module usb_busrst_chk (
  input logic clk,
  input logic rst_n,
  input logic flag_wr,
  input logic flag_wdata,
  input logic reset_flag,
  input logic reset_irq,
  input logic addr_clear,
  input logic startup_abort,
  input logic at_max
);
  // R6
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_irq |-> ($past(startup_abort) && !startup_abort));
  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_irq |=> !reset_irq);
  // R4
  clr_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clear |-> (reset_flag && startup_abort));
  // R7
  abort_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(startup_abort) |-> addr_clear);
  // R5
  clr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clear |=> !addr_clear);
  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_max && $past(at_max) |-> !addr_clear);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(reset_flag)) |-> $past(flag_wr && !flag_wdata));
endmodule

bind usb_busrst_det usb_busrst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
  .reset_flag(reset_flag), .reset_irq(reset_irq), .addr_clear(addr_clear),
  .startup_abort(startup_abort), .at_max(at_max)
);

// File: tb/test_usb_busrst_det.sv
module test_usb_busrst_det;
  localparam int CLK_PERIOD = 84;
  localparam int THR = 168;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp_in = 1'b1, dm_in = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic reset_flag, reset_irq, addr_clear, startup_abort;

  int checks = 0, failures = 0;
  int n_clr = 0, n_irq = 0;

  // behavioural model state
  bit hist[$];
  int run = 0;
  bit m_act = 0, m_flag = 0, m_irq = 0, m_clr = 0;

  usb_busrst_det i_usb_busrst_det (
    .clk(clk), .rst_n(rst_n), .dp_in(dp_in), .dm_in(dm_in),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .reset_flag(reset_flag), .reset_irq(reset_irq),
    .addr_clear(addr_clear), .startup_abort(startup_abort)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0}; run = 0;
      m_act = 0; m_flag = 0; m_irq = 0; m_clr = 0;
    end else begin
      bit se0, arm;
      se0 = hist[0];
      void'(hist.pop_front());
      hist.push_back(!dp_in && !dm_in);
      arm = se0 && (run == THR - 1);
      run = se0 ? ((run < THR) ? run + 1 : THR) : 0;
      m_clr = arm;
      m_irq = m_act && !se0;
      if (arm) m_act = 1; else if (!se0) m_act = 0;
      if (arm) m_flag = 1; else if (flag_wr && !flag_wdata) m_flag = 0;
    end
  end

  task automatic chk(string req, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3/R4", "reset_flag", reset_flag, m_flag);
    chk("R6", "reset_irq", reset_irq, m_irq);
    chk("R4/R5", "addr_clear", addr_clear, m_clr);
    chk("R7", "startup_abort", startup_abort, m_act);
    if (addr_clear) n_clr++;
    if (reset_irq) n_irq++;
  end

  task automatic drive(logic dp, logic dm, int n);
    dp_in = dp; dm_in = dm;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic v);
    flag_wr = 1'b1; flag_wdata = v;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "flag_in_reset", reset_flag, 1'b0);
    chk("R1", "abort_in_reset", startup_abort, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "flag_after_reset", reset_flag, 1'b0);
    chk("R1", "irq_after_reset", reset_irq, 1'b0);
    drive(1, 0, 5);
    // R3: one cycle short of threshold
    drive(0, 0, THR - 1); drive(1, 0, 10);
    chk("R3", "short_se0_no_flag", reset_flag, 1'b0);
    chk("R3", "short_se0_no_clr", n_clr == 0, 1'b1);
    // R2: non-SE0 states break the run
    drive(0, 0, 100); drive(1, 1, 1); drive(0, 0, 100); drive(0, 1, 1);
    drive(0, 0, 100); drive(1, 0, 10);
    chk("R2", "broken_se0_no_flag", reset_flag, 1'b0);
    // R4/R6: exact threshold
    drive(0, 0, THR); drive(1, 0, 10);
    chk("R4", "exact_flag", reset_flag, 1'b1);
    chk("R6", "exact_irq_count", n_irq == 1, 1'b1);
    // R8: write one ignored, write zero clears
    wr(1'b1); @(negedge clk);
    chk("R8", "write_one_ignored", reset_flag, 1'b1);
    wr(1'b0); @(negedge clk);
    chk("R8", "write_zero_clears", reset_flag, 1'b0);
    // R5: long SE0, single pulses
    drive(0, 0, 3 * THR);
    chk("R7", "abort_held", startup_abort, 1'b1);
    drive(0, 1, 10);
    chk("R5", "one_clr_long", n_clr == 2, 1'b1);
    chk("R5", "one_irq_long", n_irq == 2, 1'b1);
    chk("R7", "abort_released", startup_abort, 1'b0);
    // R9: clear write collides with recognition edge
    wr(1'b0);
    dp_in = 0; dm_in = 0;
    repeat (THR + 1) @(negedge clk);
    flag_wr = 1'b1; flag_wdata = 1'b0;
    @(negedge clk); flag_wr = 1'b0;
    @(negedge clk);
    chk("R9", "set_wins", reset_flag, 1'b1);
    drive(1, 0, 10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule